// File: doc/BRIEF.md
# Decrementer and Timebase Updater

This block keeps a processor's 64-bit decrementer and timebase running. Both counters live in an external state register file that also holds the program counter, machine state and vector-loop state. The file answers a read one clock after the read request. The block walks a four-step loop: it requests DEC, writes back the returned value minus one, requests TB, and writes back the returned value plus one. Each request carries a one-hot index mask.

Move-to-special-register instructions reach the same file through a second write port, and the block snoops that port's enable mask. A software write that touches DEC or TB pauses the loop. That cycle issues no request, and the loop restarts by reading DEC again, so a value fetched before the software write is never written back over it. The block also holds a cached copy of DEC for interrupt detection, and the loop refreshes that copy each time it writes DEC. A software write to DEC clears the cached copy. A stale negative value therefore cannot raise an interrupt before the loop has fetched the new one. The pending output is the cached sign bit gated by the external-interrupt enable.

Top module: `dectb_updater`

## Requirements
- R1: While reset is high: the read request is the DEC mask (bit 3, value 0x08), the write request is zero, the cached DEC is zero and the interrupt-pending output is low.
- R2: With no software writes, the block repeats four cycles: read DEC (0x08), write DEC, read TB (bit 4, 0x10), write TB. A write always follows a read of the same index by one cycle, and at most one request bit is set in any cycle.
- R3: A DEC write carries the value read in the previous cycle minus one, modulo 2^64. From zero it gives all ones.
- R4: A TB write carries the value read in the previous cycle plus one.
- R5: On the edge that ends a DEC write cycle, the cached DEC takes the written value.
- R6: In a cycle where the snooped mask has bit 3 or bit 4 set, the block issues no read or write request, and the next cycle is a read of DEC.
- R7: A snooped write with bit 3 set clears the cached DEC to zero at the next edge. A snooped write that sets only bit 4 leaves the cached DEC unchanged.
- R8: The interrupt-pending output equals bit 63 of the cached DEC ANDed with the external-interrupt enable input.
- R9: Snooped writes that set only bits 0 to 2 (PC, MSR, vector state) leave the loop running and its requests unchanged.
- R10: A value written by software to DEC or TB is never overwritten by a write derived from an older read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msr_ee | input | 1 | External-interrupt enable bit from the machine state |
| sw_wr_en | input | 5 | Snooped one-hot write mask of the special-register write port |
| rd_en | output | 5 | One-hot read request to the state file |
| rd_data | input | 64 | Read data, valid the cycle after the request |
| wr_en | output | 5 | One-hot write request to the state file |
| wr_data | output | 64 | Write data for the requested index |
| dec_cached | output | 64 | Cached DEC copy used for interrupt detection |
| irq_pending | output | 1 | Decrementer interrupt pending |

## Verification
The assertions assume that the register file returns the requested entry exactly one cycle after a read request. They also assume that a software write to an index wins over the block's own write to that index in the same cycle. The bench's register file model is built to meet both assumptions. Software writes are driven at the falling edge and held for one full cycle, so each one lands on exactly one rising edge. Writes are aimed at specific loop phases and are also scattered at random cycles. The bench tracks the expected DEC, TB and cached DEC values from its own arithmetic.

// File: rtl/dectb_pkg.sv
package dectb_pkg;
  localparam int unsigned DTB_XLEN    = 64;
  localparam int unsigned DTB_NREG    = 5;
  localparam int unsigned DTB_DEC_IDX = 3;
  localparam int unsigned DTB_TB_IDX  = 4;

  typedef enum logic [1:0] {
    ST_RD_DEC = 2'd0,
    ST_WR_DEC = 2'd1,
    ST_RD_TB  = 2'd2,
    ST_WR_TB  = 2'd3
  } dectb_state_e;
endpackage

// File: rtl/dectb_snoop.sv
module dectb_snoop #(
  parameter int unsigned NREG    = 5,
  parameter int unsigned DEC_IDX = 3,
  parameter int unsigned TB_IDX  = 4
) (
  input  logic [NREG-1:0] sw_wr_en,
  output logic            pause,
  output logic            dec_clr
);
  localparam logic [NREG-1:0] DEC_MASK   = NREG'(1) << DEC_IDX;
  localparam logic [NREG-1:0] TB_MASK    = NREG'(1) << TB_IDX;
  localparam logic [NREG-1:0] WATCH_MASK = DEC_MASK | TB_MASK;

  always_comb begin
    pause   = |(sw_wr_en & WATCH_MASK);
    dec_clr = |(sw_wr_en & DEC_MASK);
  end
endmodule

// File: rtl/dectb_fsm.sv
module dectb_fsm
  import dectb_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NREG    = 5,
  parameter int unsigned DEC_IDX = 3,
  parameter int unsigned TB_IDX  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pause,
  input  logic [XLEN-1:0] rd_data,
  output logic [NREG-1:0] rd_en,
  output logic [NREG-1:0] wr_en,
  output logic [XLEN-1:0] wr_data,
  output logic            cache_ld,
  output logic [XLEN-1:0] cache_val
);
  localparam logic [NREG-1:0] DEC_MASK = NREG'(1) << DEC_IDX;
  localparam logic [NREG-1:0] TB_MASK  = NREG'(1) << TB_IDX;
  localparam logic [XLEN-1:0] ONE      = XLEN'(1);

  dectb_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_RD_DEC: state_d = ST_WR_DEC;
      ST_WR_DEC: state_d = ST_RD_TB;
      ST_RD_TB:  state_d = ST_WR_TB;
      default:   state_d = ST_RD_DEC;
    endcase
    if (pause) state_d = ST_RD_DEC;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RD_DEC;
    else     state_q <= state_d;
  end

  always_comb begin
    rd_en     = '0;
    wr_en     = '0;
    wr_data   = rd_data;
    cache_ld  = 1'b0;
    cache_val = rd_data - ONE;
    unique case (state_q)
      ST_RD_DEC: rd_en = pause ? '0 : DEC_MASK;
      ST_WR_DEC: begin
        wr_en    = pause ? '0 : DEC_MASK;
        wr_data  = rd_data - ONE;
        cache_ld = ~pause;
      end
      ST_RD_TB:  rd_en = pause ? '0 : TB_MASK;
      default: begin
        wr_en   = pause ? '0 : TB_MASK;
        wr_data = rd_data + ONE;
      end
    endcase
  end

  AST_PAUSE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    pause |-> (wr_en == '0 && rd_en == '0)); // R6
  AST_RESTART_ON_PAUSE: assert property (@(posedge clk) disable iff (rst)
    pause |=> (rd_en == DEC_MASK || pause)); // R6
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_en, wr_en})); // R2
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |-> ($past(rd_en) == wr_en)); // R2
endmodule

// File: rtl/dectb_cache.sv
module dectb_cache #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ld,
  input  logic [XLEN-1:0] ld_val,
  input  logic            msr_ee,
  output logic [XLEN-1:0] dec_q,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst || clr) dec_q <= '0;
    else if (ld)    dec_q <= ld_val;
  end

  always_comb irq = dec_q[XLEN-1] & msr_ee;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dec_q == '0)); // R7
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (ld && !clr) |=> (dec_q == $past(ld_val))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ld && !clr) |=> $stable(dec_q)); // R7
endmodule

// File: rtl/dectb_updater.sv
module dectb_updater
  import dectb_pkg::*;
#(
  parameter int unsigned XLEN    = DTB_XLEN,
  parameter int unsigned NREG    = DTB_NREG,
  parameter int unsigned DEC_IDX = DTB_DEC_IDX,
  parameter int unsigned TB_IDX  = DTB_TB_IDX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            msr_ee,
  input  logic [NREG-1:0] sw_wr_en,
  output logic [NREG-1:0] rd_en,
  input  logic [XLEN-1:0] rd_data,
  output logic [NREG-1:0] wr_en,
  output logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] dec_cached,
  output logic            irq_pending
);
  logic            pause;
  logic            dec_clr;
  logic            cache_ld;
  logic [XLEN-1:0] cache_val;

  dectb_snoop #(.NREG(NREG), .DEC_IDX(DEC_IDX), .TB_IDX(TB_IDX)) u_snoop (
    .sw_wr_en (sw_wr_en),
    .pause    (pause),
    .dec_clr  (dec_clr)
  );

  dectb_fsm #(.XLEN(XLEN), .NREG(NREG), .DEC_IDX(DEC_IDX), .TB_IDX(TB_IDX)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pause     (pause),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cache_ld  (cache_ld),
    .cache_val (cache_val)
  );

  dectb_cache #(.XLEN(XLEN)) u_cache (
    .clk    (clk),
    .rst    (rst),
    .clr    (dec_clr),
    .ld     (cache_ld),
    .ld_val (cache_val),
    .msr_ee (msr_ee),
    .dec_q  (dec_cached),
    .irq    (irq_pending)
  );

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> msr_ee); // R8
  AST_NO_WRITE_ON_SNOOP: assert property (@(posedge clk) disable iff (rst)
    ((sw_wr_en & wr_en) != '0) |-> 1'b0); // R10
endmodule

// File: tb/dectb_updater_tb.sv
module dectb_updater_tb;
  localparam int XLEN = 64;
  localparam int NREG = 5;
  localparam logic [NREG-1:0] M_PCSET = 5'h07;
  localparam logic [NREG-1:0] M_DEC   = 5'h08;
  localparam logic [NREG-1:0] M_TB    = 5'h10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            msr_ee = 1'b0;
  logic [NREG-1:0] sw_wr_en = '0;
  logic [XLEN-1:0] sw_wr_data = '0;
  logic [NREG-1:0] rd_en, wr_en;
  logic [XLEN-1:0] rd_data, wr_data, dec_cached;
  logic            irq_pending;

  logic [XLEN-1:0] rf [NREG];
  logic [XLEN-1:0] exp_dec, exp_tb, exp_cache;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dectb_updater u_dut (
    .clk(clk), .rst(rst), .msr_ee(msr_ee), .sw_wr_en(sw_wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
    .dec_cached(dec_cached), .irq_pending(irq_pending)
  );

  // Register file model: one-cycle read latency, software write wins.
  always @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (sw_wr_en[i])   rf[i] <= sw_wr_data;
      else if (wr_en[i]) rf[i] <= wr_data;
      if (rd_en[i])      rd_data <= rf[i];
    end
  end

  // Independent expectation trackers.
  always @(posedge clk) begin
    if (sw_wr_en[3])   exp_dec <= sw_wr_data;
    else if (wr_en[3]) exp_dec <= exp_dec - 64'd1;
    if (sw_wr_en[4])   exp_tb <= sw_wr_data;
    else if (wr_en[4]) exp_tb <= exp_tb + 64'd1;
    if (rst || sw_wr_en[3]) exp_cache <= '0;
    else if (wr_en[3])      exp_cache <= exp_dec - 64'd1;
  end

  task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [NREG-1:0] m, input logic [XLEN-1:0] v);
    sw_wr_en = m; sw_wr_data = v;
    #1;
    if (!rst) begin
      check(wr_en == '0, "R6 no write on snoop", 64'(wr_en), 0);
      check(rd_en == '0, "R6 no read on snoop", 64'(rd_en), 0);
    end
    tick();
    sw_wr_en = '0;
    #1;
  endtask

  task automatic sync_rd_dec();
    for (int i = 0; i < 8 && rd_en != M_DEC; i++) tick();
  endtask

  task automatic t_reset();
    tick();
    sw_write(M_DEC, 64'd10);
    sw_write(M_TB, 64'd100);
    check(rd_en == M_DEC, "R1 rd_en", 64'(rd_en), 64'(M_DEC));
    check(wr_en == '0, "R1 wr_en", 64'(wr_en), 0);
    check(dec_cached == '0, "R1 cache", dec_cached, 0);
    check(irq_pending == 1'b0, "R1 irq", 64'(irq_pending), 0);
  endtask

  task automatic t_count();
    rst = 1'b0;
    tick(); #1;
    check(wr_en == M_DEC, "R2 wr dec phase", 64'(wr_en), 64'(M_DEC));
    check(wr_data == 64'd9, "R3 dec minus one", wr_data, 64'd9);
    tick(); #1;
    check(rd_en == M_TB, "R2 rd tb phase", 64'(rd_en), 64'(M_TB));
    check(dec_cached == 64'd9, "R5 cache load", dec_cached, 64'd9);
    tick(); #1;
    check(wr_en == M_TB && wr_data == 64'd101, "R4 tb plus one", wr_data, 64'd101);
    tick(); #1;
    check(rd_en == M_DEC, "R2 loop back", 64'(rd_en), 64'(M_DEC));
    repeat (12) tick();
    #1;
    check(rf[3] == 64'd6, "R3 dec after passes", rf[3], 64'd6);
    check(rf[4] == 64'd104, "R4 tb after passes", rf[4], 64'd104);
  endtask

  task automatic t_wrap();
    msr_ee = 1'b0;
    sw_write(M_DEC, 64'd0);
    check(rd_en == M_DEC, "R6 restart", 64'(rd_en), 64'(M_DEC));
    tick(); #1;
    check(wr_data == '1, "R3 wrap", wr_data, '1);
    tick(); #1;
    check(dec_cached == '1, "R5 cache wrap", dec_cached, '1);
    check(irq_pending == 1'b0, "R8 irq masked", 64'(irq_pending), 0);
    msr_ee = 1'b1; #1;
    check(irq_pending == 1'b1, "R8 irq enabled", 64'(irq_pending), 1);
  endtask

  task automatic t_stale();
    sync_rd_dec();
    tick();
    sw_wr_en = M_DEC; sw_wr_data = 64'd50; #1;
    check(wr_en == '0, "R6 dec write suppressed", 64'(wr_en), 0);
    tick(); sw_wr_en = '0; #1;
    check(dec_cached == '0, "R7 cache cleared", dec_cached, 0);
    check(irq_pending == 1'b0, "R7 no stale irq", 64'(irq_pending), 0);
    check(rd_en == M_DEC, "R6 reread dec", 64'(rd_en), 64'(M_DEC));
    check(rf[3] == 64'd50, "R10 sw dec kept", rf[3], 64'd50);
    tick(); #1;
    check(wr_data == 64'd49, "R10 dec from sw value", wr_data, 64'd49);
    tick(); #1;
    check(dec_cached == 64'd49, "R5 cache refreshed", dec_cached, 64'd49);
  endtask

  task automatic t_sw_tb();
    sync_rd_dec();
    tick(); tick(); tick();
    sw_wr_en = M_TB; sw_wr_data = 64'd1000; #1;
    check(wr_en == '0, "R6 tb write suppressed", 64'(wr_en), 0);
    tick(); sw_wr_en = '0; #1;
    check(rd_en == M_DEC, "R6 restart after tb", 64'(rd_en), 64'(M_DEC));
    check(dec_cached == exp_cache, "R7 tb write keeps cache", dec_cached, exp_cache);
    check(rf[4] == 64'd1000, "R10 sw tb kept", rf[4], 64'd1000);
    repeat (4) tick();
    #1;
    check(rf[4] == 64'd1001, "R4 tb from sw value", rf[4], 64'd1001);
  endtask

  task automatic t_ignore();
    sync_rd_dec();
    tick();
    sw_wr_en = M_PCSET; sw_wr_data = 64'd5; #1;
    check(wr_en == M_DEC, "R9 write not paused", 64'(wr_en), 64'(M_DEC));
    tick(); sw_wr_en = '0; #1;
    check(rd_en == M_TB, "R9 loop continues", 64'(rd_en), 64'(M_TB));
  endtask

  task automatic t_random();
    msr_ee = 1'b1;
    for (int c = 0; c < 300; c++) begin
      int r;
      r = $urandom % 12;
      case (r)
        0: sw_wr_en = M_DEC;
        1: sw_wr_en = M_TB;
        2: sw_wr_en = M_DEC | M_TB;
        3: sw_wr_en = 5'h01;
        default: sw_wr_en = '0;
      endcase
      sw_wr_data = {$urandom, $urandom};
      tick();
      #1;
      check(rf[3] == exp_dec, "R10 dec tracked", rf[3], exp_dec);
      check(rf[4] == exp_tb, "R10 tb tracked", rf[4], exp_tb);
      check(irq_pending == exp_cache[63], "R8 irq tracked", 64'(irq_pending),
            64'(exp_cache[63]));
    end
    sw_wr_en = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_count();
    t_wrap();
    t_stale();
    t_sw_tb();
    t_ignore();
    t_random();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule